// File: doc/BRIEF.md
# Prescaled Interval Timer with Waveform Output

This block is one 16-bit timer channel. A prescaler either passes every clock through as a count tick or divides the clock by a power of two. A counter steps on each tick and, in interval mode, folds back to zero when it would reach a programmed limit. The limit therefore sets the period of the waveform pin. A comparator flips the waveform pin when the count lands on a programmed compare value, and flips it again at each fold, so the compare value sets the duty cycle. Each fold can raise a status flag. An enable register gates that flag, and software acknowledges it by writing a one to it. A level interrupt follows the flags that are enabled.

Software programs the channel through a small register bus with single-cycle writes and combinational reads. A typical setup writes the clock selection, the limit, the compare value and the interrupt enable. It then writes the control word with the restart bit set, which starts the waveform from a known low level.

Top module: `ptmr_top`

## Requirements
- R1: After reset, wave_o and irq_o are 0. The control word (address 1) reads 0x0001 (halted). The limit (address 2), compare (address 3), enable (address 4) and status (address 5) registers read 0.
- R2: The clock word is at address 0, with bits 3:0 holding N and bit 4 the divide enable. With bit 4 clear, the counter steps on every clock. With bit 4 set, it steps once every 2^(N+1) clocks.
- R3: With control bit 1 (interval mode) set, the counter counts from 0 to limit-1 and then returns to 0, so one period lasts `limit` ticks. The count reads at address 6.
- R4: With control bit 2 (compare enable) set, the waveform flips in the cycle the count becomes the compare value, and it also flips at every return to 0. After a restart the waveform is low for `compare` ticks and high for `limit - compare` ticks.
- R5: Control bit 3 disables the waveform. While it is set, wave_o is 0; when it is clear, the pin follows the internal waveform.
- R6: Writing control bit 4 (restart) clears the count, the prescaler and the waveform one cycle later. Bit 4 always reads 0.
- R7: While control bit 0 (halt) is set, the count, the prescaler and the waveform hold their values, and no flag is raised.
- R8: Status bit 0 is set by a return to 0 only when enable bit 0 is set.
- R9: Writing a 1 to status bit 0 clears it, and writing a 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R10: irq_o is high exactly while some status bit and its enable bit are both 1. It drops in the cycle after the acknowledge.
- R11: Values written to the limit and compare registers read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Register access select |
| bus_wr_i | input | 1 | Write strobe, used with the select |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational from the address |
| wave_o | output | 1 | Waveform pin |
| irq_o | output | 1 | Level interrupt |

## Verification
The case that is hardest to reach is the one where the waveform timing and the flag timing are checked exactly while the channel is reprogrammed between configurations. Edges left over from an old setting would corrupt the measured high and low times. The stimulus halts the counter first, then programs the new clock division, limit and compare value, and finally restarts with the restart bit. The edge monitor is rearmed, ignores everything up to the first rising edge after the restart, and then compares each high and low segment against queued durations. Halting, acknowledge writes of zero and a disabled flag enable are each followed by readbacks of the count and the status register through the bus.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CLK = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CTL = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_IVL = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_MAT = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_IER = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_ISR = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_CNT = 3'd6;

  // control word bit positions
  localparam int CTL_RST = 4;

  typedef struct packed {
    logic wdis;   // bit 3: waveform pin disabled
    logic men;    // bit 2: compare enable
    logic ivl;    // bit 1: interval mode
    logic dis;    // bit 0: halt
  } ctl_t;
endpackage

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
  parameter int PS_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            clr_i,
  input  logic            ps_en_i,
  input  logic [PS_W-1:0] ps_val_i,
  output logic            tick_o
);
  localparam int DIV_W = 2 ** PS_W;

  logic [DIV_W-1:0] pre_q, pre_d, limit;
  logic             at_limit;

  // terminal count 2^(N+1)-1 as a right-shifted all-ones mask
  assign limit    = {DIV_W{1'b1}} >> (DIV_W - 1 - int'(ps_val_i));
  assign at_limit = (pre_q == limit);
  assign tick_o   = run_i & (~ps_en_i | at_limit);

  always_comb begin
    pre_d = pre_q;
    if (clr_i || !ps_en_i) begin
      pre_d = '0;
    end else if (run_i) begin
      pre_d = at_limit ? '0 : pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             ivl_mode_i,
  input  logic             cmp_en_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wave_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, cnt_step;
  logic             wave_q, wave_d, hit;

  assign cnt_inc  = cnt_q + 1'b1;
  assign wrap_o   = tick_i & ivl_mode_i & (cnt_inc == limit_i);
  assign cnt_step = wrap_o ? '0 : cnt_inc;
  assign hit      = tick_i & cmp_en_i & (cnt_step == cmp_i);

  always_comb begin
    cnt_d  = cnt_q;
    wave_d = wave_q;
    if (clr_i) begin
      cnt_d  = '0;
      wave_d = 1'b0;
    end else if (tick_i) begin
      cnt_d  = cnt_step;
      wave_d = wave_q ^ (wrap_o ^ hit);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wave_q <= wave_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wave_o = wave_q;
endmodule

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic              wrap_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output ctl_t              ctl_o,
  output logic              ps_en_o,
  output logic [PS_W-1:0]   ps_val_o,
  output logic [CNT_W-1:0]  limit_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              cnt_rst_o,
  output logic              ier_o,
  output logic              isr_o,
  output logic              irq_o
);
  localparam int CTL_W = $bits(ctl_t);

  ctl_t             ctl_q, ctl_d;
  logic             ps_en_q, ps_en_d, rst_q, rst_d;
  logic [PS_W-1:0]  ps_val_q, ps_val_d;
  logic [CNT_W-1:0] lim_q, lim_d, cmp_q, cmp_d;
  logic             ier_q, ier_d, isr_q, isr_d;
  logic             we, we_clk, we_ctl, we_lim, we_cmp, we_ier, we_isr;

  assign we     = sel_i & wr_i;
  assign we_clk = we & (addr_i == ADR_CLK);
  assign we_ctl = we & (addr_i == ADR_CTL);
  assign we_lim = we & (addr_i == ADR_IVL);
  assign we_cmp = we & (addr_i == ADR_MAT);
  assign we_ier = we & (addr_i == ADR_IER);
  assign we_isr = we & (addr_i == ADR_ISR);

  always_comb begin
    ps_val_d = we_clk ? wdata_i[PS_W-1:0] : ps_val_q;
    ps_en_d  = we_clk ? wdata_i[PS_W]     : ps_en_q;
    ctl_d    = we_ctl ? ctl_t'(wdata_i[CTL_W-1:0]) : ctl_q;
    rst_d    = we_ctl & wdata_i[CTL_RST];
    lim_d    = we_lim ? wdata_i : lim_q;
    cmp_d    = we_cmp ? wdata_i : cmp_q;
    ier_d    = we_ier ? wdata_i[0] : ier_q;
    // acknowledge by writing one; a fresh event takes priority
    isr_d    = (isr_q & ~(we_isr & wdata_i[0])) | (wrap_i & ier_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q    <= '{wdis: 1'b0, men: 1'b0, ivl: 1'b0, dis: 1'b1};
      ps_en_q  <= 1'b0;
      ps_val_q <= '0;
      rst_q    <= 1'b0;
      lim_q    <= '0;
      cmp_q    <= '0;
      ier_q    <= 1'b0;
      isr_q    <= 1'b0;
    end else begin
      ctl_q    <= ctl_d;
      ps_en_q  <= ps_en_d;
      ps_val_q <= ps_val_d;
      rst_q    <= rst_d;
      lim_q    <= lim_d;
      cmp_q    <= cmp_d;
      ier_q    <= ier_d;
      isr_q    <= isr_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADR_CLK: rdata_o[PS_W:0]    = {ps_en_q, ps_val_q};
      ADR_CTL: rdata_o[CTL_W-1:0] = ctl_q;
      ADR_IVL: rdata_o            = lim_q;
      ADR_MAT: rdata_o            = cmp_q;
      ADR_IER: rdata_o[0]         = ier_q;
      ADR_ISR: rdata_o[0]         = isr_q;
      ADR_CNT: rdata_o            = cnt_i;
      default: rdata_o            = '0;
    endcase
  end

  assign ctl_o     = ctl_q;
  assign ps_en_o   = ps_en_q;
  assign ps_val_o  = ps_val_q;
  assign limit_o   = lim_q;
  assign cmp_o     = cmp_q;
  assign cnt_rst_o = rst_q;
  assign ier_o     = ier_q;
  assign isr_o     = isr_q;
  assign irq_o     = isr_q & ier_q;
endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
  import ptmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic              wave_o,
  output logic              irq_o
);
  ctl_t             ctl;
  logic             ps_en, tick, cnt_rst, wrap, wave_raw, ier_q, isr_q;
  logic [PS_W-1:0]  ps_val;
  logic [CNT_W-1:0] limit, cmp, cnt_q;

  ptmr_regs #(.CNT_W(CNT_W), .PS_W(PS_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (bus_sel_i),
    .wr_i     (bus_wr_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .rdata_o  (bus_rdata_o),
    .wrap_i   (wrap),
    .cnt_i    (cnt_q),
    .ctl_o    (ctl),
    .ps_en_o  (ps_en),
    .ps_val_o (ps_val),
    .limit_o  (limit),
    .cmp_o    (cmp),
    .cnt_rst_o(cnt_rst),
    .ier_o    (ier_q),
    .isr_o    (isr_q),
    .irq_o    (irq_o)
  );

  ptmr_prescale #(.PS_W(PS_W)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (~ctl.dis),
    .clr_i   (cnt_rst),
    .ps_en_i (ps_en),
    .ps_val_i(ps_val),
    .tick_o  (tick)
  );

  ptmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .clr_i     (cnt_rst),
    .ivl_mode_i(ctl.ivl),
    .cmp_en_i  (ctl.men),
    .limit_i   (limit),
    .cmp_i     (cmp),
    .cnt_o     (cnt_q),
    .wave_o    (wave_raw),
    .wrap_o    (wrap)
  );

  assign wave_o = wave_raw & ~ctl.wdis;
endmodule

// File: rtl/ptmr_checker.sv
module ptmr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnt_rst,
  input logic             halt,
  input logic [CNT_W-1:0] cnt_q,
  input logic             wave_raw,
  input logic             wrap,
  input logic             ier_q,
  input logic             isr_q,
  input logic             irq_o,
  input logic             ack_wr
);
  // R6: restart clears count and waveform
  p_restart_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_rst |=> (cnt_q == '0) && !wave_raw);

  // R7: halted channel holds count and waveform
  p_halt_holds_cnt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && !cnt_rst) |=> $stable(cnt_q));
  p_halt_holds_wave_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && !cnt_rst) |=> $stable(wave_raw));

  // R3: a fold lands on zero
  p_fold_to_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap && !cnt_rst) |=> (cnt_q == '0));

  // R8: a flag only appears with its enable set
  p_flag_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(isr_q) |-> $past(ier_q));

  // R10: acknowledge without a new event drops the interrupt
  p_ack_drops_irq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_wr && !wrap) |=> !irq_o);
endmodule

bind ptmr_top ptmr_checker #(.CNT_W(CNT_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cnt_rst (cnt_rst),
  .halt    (ctl.dis),
  .cnt_q   (cnt_q),
  .wave_raw(wave_raw),
  .wrap    (wrap),
  .ier_q   (ier_q),
  .isr_q   (isr_q),
  .irq_o   (irq_o),
  .ack_wr  (bus_sel_i & bus_wr_i & (bus_addr_i == ptmr_pkg::ADR_ISR) & bus_wdata_i[0])
);

// File: tb/ptmr_top_tb_top.sv
module ptmr_top_tb_top;
  import ptmr_pkg::*;

  logic        clk, rst_n, sel, wr, wave, irq;
  logic [2:0]  addr;
  logic [15:0] wdata, rdata;

  int nchk = 0;
  int nbad = 0;
  int cyc = 0;
  int restart_id = 0;
  int exp_q[$];
  bit finished = 0;

  ptmr_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .wave_o(wave), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output int v);
    @(negedge clk);
    addr = a;
    #1 v = int'(rdata);
  endtask

  task automatic wait_irq(output int at);
    at = -1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (irq) begin at = cyc; break; end
    end
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 3000; i++) begin
      if (exp_q.size() == 0) break;
      @(negedge clk);
    end
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // monitor: measures segments between waveform edges, compares to queue
  initial begin
    int last, seen;
    logic prev;
    bit armed;
    last = 0; seen = 0; prev = 1'b0; armed = 0;
    forever begin
      @(negedge clk);
      if (seen != restart_id) begin
        seen = restart_id; armed = 0; prev = wave;
      end else if (wave !== prev) begin
        if (!armed) begin
          if (wave) begin armed = 1; last = cyc; end
        end else begin
          if (exp_q.size() > 0) begin
            int e;
            e = exp_q.pop_front();
            check((cyc - last) == e, "R4 segment length", cyc - last, e);
          end
          last = cyc;
        end
        prev = wave;
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    int v, v2, t0, t1, w1;
    bit saw_high, saw_bad;
    sel = 0; wr = 0; addr = '0; wdata = '0; rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check(wave == 1'b0, "R1 wave", wave, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    bus_read(ADR_CTL, v); check(v == 1, "R1 ctl", v, 1);
    bus_read(ADR_IVL, v); check(v == 0, "R1 limit", v, 0);
    bus_read(ADR_ISR, v); check(v == 0, "R1 status", v, 0);

    // config A: undivided, limit 100, compare 25 (R2 R3 R4)
    restart_id++;
    bus_write(ADR_CLK, 16'h0000);
    bus_write(ADR_IVL, 16'd100);
    bus_write(ADR_MAT, 16'd25);
    bus_write(ADR_IER, 16'd1);
    bus_read(ADR_IVL, v); check(v == 100, "R11 limit readback", v, 100);
    bus_read(ADR_MAT, v); check(v == 25, "R11 compare readback", v, 25);
    exp_q.push_back(75); exp_q.push_back(25);
    exp_q.push_back(75); exp_q.push_back(25);
    bus_write(ADR_CTL, 16'h0016);
    bus_read(ADR_CTL, v); check(v == 6, "R6 restart bit reads 0", v, 6);

    t0 = -1;
    for (int k = 0; k < 3; k++) begin
      wait_irq(t1);
      check(t1 >= 0, "R10 irq raised", t1, 1);
      if (t0 >= 0) check((t1 - t0) == 100, "R3 period between flags", t1 - t0, 100);
      t0 = t1;
      bus_read(ADR_ISR, v); check(v == 1, "R8 flag set", v, 1);
      bus_write(ADR_ISR, 16'd1);
      check(irq == 1'b0, "R10 irq drops after ack", irq, 0);
    end
    drain("R4 queue drained");

    // R9 writing zero leaves flag
    wait_irq(t1);
    bus_write(ADR_ISR, 16'd0);
    bus_read(ADR_ISR, v); check(v == 1, "R9 zero write keeps flag", v, 1);
    check(irq == 1'b1, "R10 irq held", irq, 1);
    bus_write(ADR_ISR, 16'd1);

    // R8 disabled enable: no flag
    bus_write(ADR_IER, 16'd0);
    bus_write(ADR_ISR, 16'd1);
    repeat (250) @(negedge clk);
    bus_read(ADR_ISR, v); check(v == 0, "R8 no flag without enable", v, 0);
    check(irq == 1'b0, "R10 irq low", irq, 0);

    // R7 halt holds everything
    bus_write(ADR_IER, 16'd1);
    bus_write(ADR_CTL, 16'h0007);
    bus_write(ADR_ISR, 16'd1);
    bus_read(ADR_CNT, v); w1 = int'(wave);
    repeat (150) @(negedge clk);
    bus_read(ADR_CNT, v2);
    check(v2 == v, "R7 count held", v2, v);
    check(int'(wave) == w1, "R7 wave held", wave, w1);
    bus_read(ADR_ISR, v); check(v == 0, "R7 no flag while halted", v, 0);

    // R6 restart while halted
    bus_write(ADR_CTL, 16'h0017);
    bus_read(ADR_CNT, v); check(v == 0, "R6 count cleared", v, 0);
    check(wave == 1'b0, "R6 wave cleared", wave, 0);

    // R5 pin disabled
    bus_write(ADR_CTL, 16'h001E);
    saw_bad = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (wave) saw_bad = 1;
    end
    check(!saw_bad, "R5 pin low while disabled", saw_bad, 0);
    bus_write(ADR_CTL, 16'h0006);
    saw_high = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (wave) saw_high = 1;
    end
    check(saw_high, "R5 pin follows when enabled", saw_high, 1);

    // R2 divide by 2: limit 20, compare 5 -> high 30 low 10
    bus_write(ADR_CTL, 16'h0001);
    restart_id++;
    exp_q.delete();
    bus_write(ADR_CLK, 16'h0010);
    bus_write(ADR_IVL, 16'd20);
    bus_write(ADR_MAT, 16'd5);
    exp_q.push_back(30); exp_q.push_back(10);
    exp_q.push_back(30); exp_q.push_back(10);
    bus_write(ADR_CTL, 16'h0016);
    drain("R2 divide by 2 drained");

    // R2 divide by 4: limit 10, compare 3 -> high 28 low 12
    bus_write(ADR_CTL, 16'h0001);
    restart_id++;
    exp_q.delete();
    bus_write(ADR_CLK, 16'h0011);
    bus_write(ADR_IVL, 16'd10);
    bus_write(ADR_MAT, 16'd3);
    exp_q.push_back(28); exp_q.push_back(12); exp_q.push_back(28);
    bus_write(ADR_CTL, 16'h0016);
    drain("R2 divide by 4 drained");
    bus_read(ADR_CLK, v); check(v == 16'h11, "R2 clock word readback", v, 17);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule